// File: doc/BRIEF.md
# Dual-User Memory Data Port Switch with SEC-DED Protection

This block connects two 16-bit user data ports to one memory data port that stores 16 data bits plus 6 check bits. A command is presented for one clock cycle. The command names an operation, an active user, a destination user and a listen request. From it the block decides which bus drives outward and what data each bus carries. A memory write encodes the active user's data and drives it, with its check bits, toward memory. A memory read decodes the memory word, optionally repairs a single-bit error, and returns the data to the active user. A bypass transfer moves data from one user port straight to the other without touching memory. During a memory read or write, the idle user can ask to receive a copy of the data moving across the memory port.

All ports are modelled as split input, output and output-enable signals, so the pads live outside the block. Every output is registered and reflects the command sampled one clock edge earlier. The block holds no other state.

Top module: `dual_port_edac_switch`

## Requirements
- R1: While reset is held, and until the synchronised reset has released, every output enable, every error flag and the illegal flag read 0.
- R2: A cycle with `cmd_valid` low leaves all three output enables, both error flags and `cmd_illegal` at 0 on the next cycle.
- R3: `cmd_op` = 2'b00 (write) with `cmd_user` = u: on the next cycle `mem_oe` is 1, `mem_dout` carries user u's input data and `mem_cout` carries its check bits. User u's output enable is 0, and no error flag is set.
- R4: The check code places data bits, lowest first, at codeword positions 3, 5, 6, 7, 9, … (every position that is not a power of two). Check bit k (k = 0..4) is the XOR of the data bits whose position has bit k set. Check bit 5 is the XOR of all 16 data bits and check bits 0..4.
- R5: `cmd_op` = 2'b01 (read) with `cmd_user` = u: on the next cycle user u's output enable is 1 and it carries the decoded memory data; `mem_oe` is 0.
- R6: When `cmd_listen` is 1 on a read or a write, the other user's output enable is 1 on the next cycle. On a write it carries the active user's data; on a read it carries the same decoded data and the same error flags as the active user. With `cmd_listen` at 0, that user's enable stays 0.
- R7: `cmd_op` = 2'b10 (transfer) with `cmd_user` ≠ `cmd_dst`: the destination port's enable is 1 and it carries the source user's input data. `mem_oe`, the source port's enable and both error flags are 0, and `cmd_listen` has no effect.
- R8: A transfer whose `cmd_dst` equals `cmd_user`, and any command with `cmd_op` = 2'b11, enables no output and sets `cmd_illegal` to 1 for one cycle.
- R9: A read with exactly one flipped bit anywhere in the 22-bit word sets `err_corr` = 1 and `err_uncorr` = 0. With `corr_en` = 1 the returned data equals the originally written data.
- R10: With `corr_en` = 0, a read with one flipped data bit still sets `err_corr`, but the data is returned unrepaired.
- R11: A read with two flipped bits sets `err_uncorr` = 1 and `err_corr` = 0, and the returned data is the raw memory data. The two flags are never 1 together, and they are 0 on every cycle that is not a read.
- R12: Each data output reads 0 whenever its output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 write, 01 read, 10 transfer, 11 illegal |
| cmd_user | input | 1 | Active (source or requesting) user |
| cmd_dst | input | 1 | Destination user for a transfer |
| cmd_listen | input | 1 | Other user receives a copy on a memory cycle |
| corr_en | input | 1 | 1 repairs single-bit errors, 0 only detects them |
| u0_din | input | 16 | Data arriving from user 0 |
| u1_din | input | 16 | Data arriving from user 1 |
| mem_din | input | 16 | Data bits arriving from memory |
| mem_cin | input | 6 | Check bits arriving from memory |
| u0_dout | output | 16 | Data driven toward user 0 |
| u0_oe | output | 1 | User 0 port drives outward |
| u1_dout | output | 16 | Data driven toward user 1 |
| u1_oe | output | 1 | User 1 port drives outward |
| mem_dout | output | 16 | Data bits driven toward memory |
| mem_cout | output | 6 | Check bits driven toward memory |
| mem_oe | output | 1 | Memory port drives outward |
| err_corr | output | 1 | Single-bit error seen on this read |
| err_uncorr | output | 1 | Uncorrectable error seen on this read |
| cmd_illegal | output | 1 | Previous command was rejected |

## Verification
The hardest cases to reach are reads whose flipped bit lies in a check bit, or in the overall parity bit, rather than in the data. The flags must still mark the error as correctable, yet the data must come back unchanged. The bench computes clean check bits with its own model of the code and then XORs chosen single and double masks into the memory-side word. This reaches each error class on purpose, in both correcting and detect-only modes and with a listener attached. Random writes and reads follow these targeted cases.

// File: rtl/edsw_pkg.sv
package edsw_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_XFER  = 2'b10,
    OP_BAD   = 2'b11
  } op_e;

  // Number of Hamming bits needed to cover dw data bits.
  function automatic int ham_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position of data bit j: the j-th position that is not a power of two.
  function automatic int data_pos(int j);
    int n;
    n = 0;
    for (int p = 3; p < 512; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) return p;
        n++;
      end
    end
    return 0;
  endfunction

  // Data bits that feed Hamming bit k.
  function automatic logic [63:0] col_mask(int k, int dw);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < 64; j++) begin
      if (j < dw) begin
        if (((data_pos(j) >> k) & 1) == 1) m[j] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/edsw_encoder.sv
module edsw_encoder
  import edsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5,
  parameter int CHK_W  = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] ham;

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [63:0] MASK_FULL = col_mask(k, DATA_W);
    localparam logic [DATA_W-1:0] MASK = MASK_FULL[DATA_W-1:0];
    assign ham[k] = ^(data_i & MASK);
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/edsw_decoder.sv
module edsw_decoder
  import edsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5,
  parameter int CHK_W  = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic              corr_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              multi_o
);

  logic [HAM_W-1:0]  syn;
  logic [DATA_W-1:0] hit;
  logic              par_bad;

  for (genvar k = 0; k < HAM_W; k++) begin : g_syn
    localparam logic [63:0] MASK_FULL = col_mask(k, DATA_W);
    localparam logic [DATA_W-1:0] MASK = MASK_FULL[DATA_W-1:0];
    assign syn[k] = chk_i[k] ^ (^(data_i & MASK));
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_hit
    localparam int P = data_pos(j);
    assign hit[j] = (syn == HAM_W'(P));
  end

  assign par_bad = (^data_i) ^ (^chk_i);

  always_comb begin
    single_o = 1'b0;
    multi_o  = 1'b0;
    if (par_bad) begin
      // odd weight: one error unless the syndrome points nowhere
      if (syn == '0 || $onehot(syn) || (|hit)) single_o = 1'b1;
      else                                       multi_o  = 1'b1;
    end else if (syn != '0) begin
      multi_o = 1'b1;
    end
    data_o = (single_o && corr_en_i) ? (data_i ^ hit) : data_i;
  end

endmodule

// File: rtl/edsw_cmd_dec.sv
module edsw_cmd_dec
  import edsw_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic       user_i,
  input  logic       dst_i,
  input  logic       listen_i,
  output logic [1:0] user_oe_o,
  output logic       mem_oe_o,
  output logic       is_read_o,
  output logic       illegal_o
);

  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    user_oe_o = 2'b00;
    mem_oe_o  = 1'b0;
    is_read_o = 1'b0;
    illegal_o = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_WRITE: begin
          mem_oe_o = 1'b1;
          if (listen_i) user_oe_o[~user_i] = 1'b1;
        end
        OP_READ: begin
          is_read_o         = 1'b1;
          user_oe_o[user_i] = 1'b1;
          if (listen_i) user_oe_o[~user_i] = 1'b1;
        end
        OP_XFER: begin
          if (dst_i == user_i) illegal_o = 1'b1;
          else                 user_oe_o[dst_i] = 1'b1;
        end
        default: illegal_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dual_port_edac_switch.sv
module dual_port_edac_switch
  import edsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_user,
  input  logic              cmd_dst,
  input  logic              cmd_listen,
  input  logic              corr_en,
  input  logic [DATA_W-1:0] u0_din,
  input  logic [DATA_W-1:0] u1_din,
  input  logic [DATA_W-1:0] mem_din,
  input  logic [CHK_W-1:0]  mem_cin,
  output logic [DATA_W-1:0] u0_dout,
  output logic              u0_oe,
  output logic [DATA_W-1:0] u1_dout,
  output logic              u1_oe,
  output logic [DATA_W-1:0] mem_dout,
  output logic [CHK_W-1:0]  mem_cout,
  output logic              mem_oe,
  output logic              err_corr,
  output logic              err_uncorr,
  output logic              cmd_illegal
);

  // reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_sync[SYNC_STAGES-1];

  // command decode
  logic [1:0] user_oe;
  logic       mem_we, is_read, illegal;

  edsw_cmd_dec u_cmd (
    .valid_i  (cmd_valid),
    .op_i     (cmd_op),
    .user_i   (cmd_user),
    .dst_i    (cmd_dst),
    .listen_i (cmd_listen),
    .user_oe_o(user_oe),
    .mem_oe_o (mem_we),
    .is_read_o(is_read),
    .illegal_o(illegal)
  );

  // datapath
  logic [DATA_W-1:0] src_data, rd_data;
  logic [CHK_W-1:0]  enc_chk;
  logic              rd_single, rd_multi;
  logic [DATA_W-1:0] din [2];

  assign din[0]   = u0_din;
  assign din[1]   = u1_din;
  assign src_data = din[cmd_user];

  edsw_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_enc (
    .data_i(src_data),
    .chk_o (enc_chk)
  );

  edsw_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_dec (
    .data_i   (mem_din),
    .chk_i    (mem_cin),
    .corr_en_i(corr_en),
    .data_o   (rd_data),
    .single_o (rd_single),
    .multi_o  (rd_multi)
  );

  // next state
  logic [DATA_W-1:0] u_dout_d [2];
  logic [DATA_W-1:0] u_dout_q [2];
  logic [1:0]        u_oe_q;
  logic [DATA_W-1:0] mem_dout_d, mem_dout_q;
  logic [CHK_W-1:0]  mem_cout_d, mem_cout_q;
  logic              mem_oe_q, corr_d, corr_q, uncorr_d, uncorr_q, ill_q;
  logic              busy_q, upd_en;

  for (genvar i = 0; i < 2; i++) begin : g_user
    // a user port is fed either by the decoder or by the other user
    always_comb begin
      if (!user_oe[i]) u_dout_d[i] = '0;
      else if (is_read) u_dout_d[i] = rd_data;
      else              u_dout_d[i] = din[1-i];
    end
  end

  always_comb begin
    mem_dout_d = mem_we ? src_data : '0;
    mem_cout_d = mem_we ? enc_chk  : '0;
    corr_d     = is_read & rd_single;
    uncorr_d   = is_read & rd_multi;
  end

  assign busy_q = (|u_oe_q) | mem_oe_q | corr_q | uncorr_q | ill_q;
  assign upd_en = cmd_valid | busy_q;

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      u_dout_q[0] <= '0;
      u_dout_q[1] <= '0;
      u_oe_q      <= '0;
      mem_dout_q  <= '0;
      mem_cout_q  <= '0;
      mem_oe_q    <= 1'b0;
      corr_q      <= 1'b0;
      uncorr_q    <= 1'b0;
      ill_q       <= 1'b0;
    end else if (upd_en) begin
      u_dout_q[0] <= u_dout_d[0];
      u_dout_q[1] <= u_dout_d[1];
      u_oe_q      <= user_oe;
      mem_dout_q  <= mem_dout_d;
      mem_cout_q  <= mem_cout_d;
      mem_oe_q    <= mem_we;
      corr_q      <= corr_d;
      uncorr_q    <= uncorr_d;
      ill_q       <= illegal;
    end
  end

  assign u0_dout     = u_dout_q[0];
  assign u1_dout     = u_dout_q[1];
  assign u0_oe       = u_oe_q[0];
  assign u1_oe       = u_oe_q[1];
  assign mem_dout    = mem_dout_q;
  assign mem_cout    = mem_cout_q;
  assign mem_oe      = mem_oe_q;
  assign err_corr    = corr_q;
  assign err_uncorr  = uncorr_q;
  assign cmd_illegal = ill_q;

endmodule

// File: rtl/edsw_checker.sv
module edsw_checker #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              cmd_user,
  input logic              cmd_dst,
  input logic [DATA_W-1:0] u0_din,
  input logic [DATA_W-1:0] u1_din,
  input logic [DATA_W-1:0] u0_dout,
  input logic              u0_oe,
  input logic [DATA_W-1:0] u1_dout,
  input logic              u1_oe,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_oe,
  input logic              err_corr,
  input logic              err_uncorr,
  input logic              cmd_illegal
);

  // R2
  idle_all_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !cmd_valid |=> !u0_oe && !u1_oe && !mem_oe && !err_corr && !err_uncorr && !cmd_illegal);

  // R3
  write_drives_mem_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_valid && cmd_op == 2'b00 |=>
      mem_oe && !err_corr && !err_uncorr &&
      mem_dout == ($past(cmd_user) ? $past(u1_din) : $past(u0_din)));

  // R5
  read_mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_valid && cmd_op == 2'b01 |=> !mem_oe && ($past(cmd_user) ? u1_oe : u0_oe));

  // R7
  xfer_bypass_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_valid && cmd_op == 2'b10 && cmd_user != cmd_dst |=>
      !mem_oe && !err_corr && !err_uncorr && ($past(cmd_user) ? !u1_oe && u0_oe : !u0_oe && u1_oe));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_illegal |-> !u0_oe && !u1_oe && !mem_oe);

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({err_corr, err_uncorr}));

  // R11
  flags_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    mem_oe |-> !err_corr && !err_uncorr);

  // R12
  zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!u0_oe |-> u0_dout == '0) and (!u1_oe |-> u1_dout == '0) and (!mem_oe |-> mem_dout == '0));

endmodule

bind dual_port_edac_switch edsw_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_edsw_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_user   (cmd_user),
  .cmd_dst    (cmd_dst),
  .u0_din     (u0_din),
  .u1_din     (u1_din),
  .u0_dout    (u0_dout),
  .u0_oe      (u0_oe),
  .u1_dout    (u1_dout),
  .u1_oe      (u1_oe),
  .mem_dout   (mem_dout),
  .mem_oe     (mem_oe),
  .err_corr   (err_corr),
  .err_uncorr (err_uncorr),
  .cmd_illegal(cmd_illegal)
);

// File: tb/dual_port_edac_switch_bench.sv
module dual_port_edac_switch_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_user, cmd_dst, cmd_listen, corr_en;
  logic [1:0]  cmd_op;
  logic [15:0] u0_din, u1_din, mem_din;
  logic [5:0]  mem_cin;
  logic [15:0] u0_dout, u1_dout, mem_dout;
  logic [5:0]  mem_cout;
  logic        u0_oe, u1_oe, mem_oe, err_corr, err_uncorr, cmd_illegal;

  always #2 clk = ~clk;

  dual_port_edac_switch u_dual_port_edac_switch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_user(cmd_user), .cmd_dst(cmd_dst), .cmd_listen(cmd_listen), .corr_en(corr_en),
    .u0_din(u0_din), .u1_din(u1_din), .mem_din(mem_din), .mem_cin(mem_cin),
    .u0_dout(u0_dout), .u0_oe(u0_oe), .u1_dout(u1_dout), .u1_oe(u1_oe),
    .mem_dout(mem_dout), .mem_cout(mem_cout), .mem_oe(mem_oe),
    .err_corr(err_corr), .err_uncorr(err_uncorr), .cmd_illegal(cmd_illegal)
  );

  typedef struct {
    logic        u0_oe, u1_oe, mem_oe, corr, uncorr, ill;
    logic [15:0] u0_d, u1_d, mem_d;
    logic [5:0]  mem_c;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Check code per R4: walk codeword positions, skipping powers of two.
  function automatic logic [4:0] pos_xor(logic [15:0] d);
    int         j = 0;
    logic [4:0] acc = '0;
    for (int pos = 1; j < 16; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[j]) acc ^= 5'(pos);
        j++;
      end
    end
    return acc;
  endfunction

  function automatic logic [5:0] code_of(logic [15:0] d);
    logic [4:0] h = pos_xor(d);
    return {(^d) ^ (^h), h};
  endfunction

  // position of data bit idx in the codeword
  function automatic int pos_of(int idx);
    int j = 0;
    for (int pos = 3; pos < 64; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (j == idx) return pos;
        j++;
      end
    end
    return 0;
  endfunction

  function automatic exp_t model(logic v, logic [1:0] op, logic usr, logic dst, logic lst,
                                 logic ce, logic [15:0] a, logic [15:0] b,
                                 logic [15:0] md, logic [5:0] mc, string tag);
    exp_t        e;
    logic [15:0] src, rd;
    logic [4:0]  syn;
    logic        par, sgl, mul;
    e = '{default: 0};
    e.tag = tag;
    src = usr ? b : a;
    if (!v) return e;
    if (op == 2'b00) begin
      e.mem_oe = 1; e.mem_d = src; e.mem_c = code_of(src);
      if (lst) begin
        if (usr) begin e.u0_oe = 1; e.u0_d = src; end
        else     begin e.u1_oe = 1; e.u1_d = src; end
      end
    end else if (op == 2'b01) begin
      syn = pos_xor(md) ^ mc[4:0];
      par = (^md) ^ (^mc);
      sgl = 0; mul = 0; rd = md;
      if (par) begin
        sgl = 1;
        if (syn != 0 && (syn & (syn - 1)) != 0) begin
          mul = 1;
          for (int k = 0; k < 16; k++) if (pos_of(k) == int'(syn)) mul = 0;
          if (mul) sgl = 0;
          else if (ce) for (int k = 0; k < 16; k++) if (pos_of(k) == int'(syn)) rd[k] = ~rd[k];
        end
      end else if (syn != 0) mul = 1;
      e.corr = sgl; e.uncorr = mul;
      if (usr || lst) begin e.u1_oe = 1; e.u1_d = rd; end
      if (!usr || lst) begin e.u0_oe = 1; e.u0_d = rd; end
    end else if (op == 2'b10 && usr != dst) begin
      if (dst) begin e.u1_oe = 1; e.u1_d = a; end
      else     begin e.u0_oe = 1; e.u0_d = b; end
    end else begin
      e.ill = 1;
    end
    return e;
  endfunction

  task automatic apply(logic v, logic [1:0] op, logic usr, logic dst, logic lst, logic ce,
                       logic [15:0] a, logic [15:0] b, logic [15:0] md, logic [5:0] mc,
                       string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_user = usr; cmd_dst = dst; cmd_listen = lst;
    corr_en = ce; u0_din = a; u1_din = b; mem_din = md; mem_cin = mc;
    q.push_back(model(v, op, usr, dst, lst, ce, a, b, md, mc, tag));
  endtask

  task automatic idle(string tag);
    apply(0, 2'b00, 0, 0, 0, 1, 16'h0, 16'h0, 16'h0, 6'h0, tag);
  endtask

  // Monitor: compare after each active edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if ({u0_oe, u1_oe, mem_oe, err_corr, err_uncorr, cmd_illegal} !==
              {e.u0_oe, e.u1_oe, e.mem_oe, e.corr, e.uncorr, e.ill} ||
            u0_dout !== e.u0_d || u1_dout !== e.u1_d || mem_dout !== e.mem_d ||
            mem_cout !== e.mem_c) begin
          n_fail++;
          $display("FAIL %s: got oe=%b%b%b fl=%b%b%b u0=%h u1=%h m=%h c=%h exp oe=%b%b%b fl=%b%b%b u0=%h u1=%h m=%h c=%h",
                   e.tag, u0_oe, u1_oe, mem_oe, err_corr, err_uncorr, cmd_illegal,
                   u0_dout, u1_dout, mem_dout, mem_cout,
                   e.u0_oe, e.u1_oe, e.mem_oe, e.corr, e.uncorr, e.ill,
                   e.u0_d, e.u1_d, e.mem_d, e.mem_c);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [5:0]  c;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_op = 0; cmd_user = 0; cmd_dst = 0; cmd_listen = 0; corr_en = 1;
    u0_din = 0; u1_din = 0; mem_din = 0; mem_cin = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if ({u0_oe, u1_oe, mem_oe, err_corr, err_uncorr, cmd_illegal} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1: got %b exp 000000", {u0_oe, u1_oe, mem_oe, err_corr, err_uncorr, cmd_illegal});
    end
    rst_n = 1'b1;
    repeat (3) idle("R1 release");

    // R3 R4: writes, with and without listener
    apply(1, 2'b00, 0, 0, 0, 1, 16'hA5C3, 16'h1111, 0, 0, "R3 write u0");
    apply(1, 2'b00, 1, 0, 1, 1, 16'h2222, 16'h0001, 0, 0, "R6 write u1 listen");
    apply(1, 2'b00, 0, 0, 1, 1, 16'hFFFF, 16'h0, 0, 0, "R4 write all ones");
    idle("R2 idle after write");

    // R5 R6: clean reads
    d = 16'h3C5A; c = code_of(d);
    apply(1, 2'b01, 0, 0, 0, 1, 0, 0, d, c, "R5 read u0");
    apply(1, 2'b01, 1, 0, 1, 1, 0, 0, d, c, "R6 read u1 listen");
    apply(1, 2'b01, 1, 0, 0, 1, 0, 0, 16'h0, code_of(16'h0), "R5 read zero");

    // R9: single errors in data, check, overall parity; with listener
    apply(1, 2'b01, 0, 0, 1, 1, 0, 0, d ^ 16'h0100, c, "R9 data bit flip");
    apply(1, 2'b01, 1, 0, 0, 1, 0, 0, d, c ^ 6'h04, "R9 check bit flip");
    apply(1, 2'b01, 0, 0, 0, 1, 0, 0, d, c ^ 6'h20, "R9 parity bit flip");
    apply(1, 2'b01, 0, 0, 0, 1, 0, 0, d ^ 16'h8000, c, "R9 top data bit");
    // R10: detect-only
    apply(1, 2'b01, 0, 0, 1, 0, 0, 0, d ^ 16'h0008, c, "R10 detect only");
    // R11: double errors
    apply(1, 2'b01, 0, 0, 0, 1, 0, 0, d ^ 16'h0011, c, "R11 two data bits");
    apply(1, 2'b01, 1, 0, 1, 1, 0, 0, d ^ 16'h0002, c ^ 6'h01, "R11 data and check");
    idle("R2 idle after read");

    // R7: bypass transfers, listen ignored
    apply(1, 2'b10, 0, 1, 1, 1, 16'hBEEF, 16'h0, 0, 0, "R7 xfer 0 to 1");
    apply(1, 2'b10, 1, 0, 0, 1, 16'h0, 16'hCAFE, 16'hFFFF, 6'h3F, "R7 xfer 1 to 0");
    // R8: illegal commands
    apply(1, 2'b10, 0, 0, 0, 1, 16'h1234, 16'h5678, 0, 0, "R8 xfer to self");
    apply(1, 2'b10, 1, 1, 1, 1, 16'h1234, 16'h5678, 0, 0, "R8 xfer to self u1");
    apply(1, 2'b11, 0, 1, 1, 1, 16'h1234, 16'h5678, 0, 0, "R8 op 11");
    idle("R2 idle after illegal");
    idle("R12 idle zeros");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] r;
      logic [5:0]  rc;
      logic [4:0]  b1;
      r  = 16'($urandom);
      rc = code_of(r);
      b1 = 5'($urandom_range(0, 21));
      if (b1 < 16) r[b1] = ~r[b1];
      else         rc[b1-16] = ~rc[b1-16];
      apply(($urandom_range(0, 5) != 0), 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), r, rc, "R9 random");
    end
    idle("R2 final");
    idle("R2 final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule